// File: doc/BRIEF.md
# Trigger-Locked Pulse Integration Sequencer

This block drives the control strobes of a charge-integrating analogue front end for a pulsed radiation source whose repetition rate is not fixed. No period is programmed. Each accepted rising edge of the asynchronous trigger starts a full acquisition cycle. The cycle runs a fixed-length integrator reset, then a one-cycle reset-level sample strobe, then an optional fixed delay, then an integration window of programmable length. It ends with a one-cycle signal-sample strobe followed by a one-cycle readout start.

After the readout start the sequencer waits for a readout-done handshake before it accepts another trigger. Trigger edges that arrive while a cycle is in progress are discarded. They are tallied in a saturating drop counter so that software can detect missed pulses. The reset length is given in nanoseconds and converted to clock cycles at elaboration. At the default 15 MHz clock and 8600 ns this gives 129 cycles. Elaboration is rejected above 15 MHz.

Top module: `pseq_top`

## Requirements
- R1: After reset all five strobes are low and `drop_cnt` is zero.
- R2: When idle, a rising edge on `trig_in` passes through a two-flop synchroniser and edge detector. `irst` goes high at the third rising clock edge after `trig_in` rises. It stays high for exactly RST_CYC = CLK_HZ*RST_NS/1e9 cycles, which is 129 at the defaults.
- R3: `shr` is high for exactly one cycle, in the cycle immediately after `irst` falls.
- R4: With the offset not applied, `intg` rises in the cycle right after `shr`. It stays high for `int_len` cycles, and an `int_len` of 0 is treated as 1.
- R5: With `ofs_en` high and `ofs_len` nonzero, `intg` rises `ofs_len` cycles after the cycle following `shr`. All strobes stay low during that delay. With `ofs_en` low, `ofs_len` has no effect.
- R6: `shs` is high for exactly one cycle, in the cycle immediately after `intg` falls.
- R7: `rd_start` is high for exactly one cycle, in the cycle after `shs`. The block then keeps all strobes low until `rd_done` is seen high in a later cycle, and only then becomes idle.
- R8: A synchronised trigger rising edge that arrives when the block is not idle is ignored. This includes the wait for `rd_done`. Each such edge increments `drop_cnt` by one, and the count saturates at all ones.
- R9: `int_len`, `ofs_en` and `ofs_len` are captured when a trigger is accepted. Changes made to them later do not affect the cycle in progress.
- R10: A trigger held high across the end of a cycle does not start a new one. Only a fresh rising edge does.
- R11: At most one of `irst`, `shr`, `intg`, `shs` and `rd_start` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock, at most 15 MHz |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_in | input | 1 | Asynchronous source trigger |
| int_len | input | LEN_W (12) | Integration window length in cycles |
| ofs_en | input | 1 | Apply the integration start delay |
| ofs_len | input | OFS_W (12) | Integration start delay in cycles |
| rd_done | input | 1 | Readout finished handshake |
| irst | output | 1 | Integrator reset strobe |
| shr | output | 1 | Reset-level sample strobe |
| intg | output | 1 | Integration window |
| shs | output | 1 | Signal-level sample strobe |
| rd_start | output | 1 | Readout start pulse |
| drop_cnt | output | CNT_W (8) | Saturating count of discarded triggers |

## Verification
The assertions check several properties on every cycle:
- the strobes are mutually exclusive;
- the reset phase has its exact length;
- the reset sample, signal sample and readout start each follow their predecessor with no gap;
- the drop counter only ever steps up by one.

The bench's scenarios are needed for the rest:
- the absolute latency from the trigger pin;
- integration length and delay, swept over values including zero and the maximum;
- capture of the settings at trigger time;
- rejection of a held trigger;
- counter saturation.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

   typedef enum logic [2:0] {
      S_IDLE,
      S_RST,
      S_SHR,
      S_DLY,
      S_INT,
      S_SHS,
      S_RDS,
      S_WAIT
   } pseq_state_e;

   localparam int unsigned MAX_CLK_HZ = 15_000_000;

   // Reset duration in clock cycles, computed in 64-bit to avoid overflow.
   function automatic int unsigned rst_cycles(input int unsigned hz, input int unsigned ns);
      longint unsigned prod;
      prod = longint'(hz) * longint'(ns);
      return int'(prod / 64'd1_000_000_000);
   endfunction

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pseq_sync.sv
// Multi-stage synchroniser followed by a rising-edge detector.
module pseq_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);

   logic [STAGES-1:0] q;
   logic              last_q;

   if (STAGES < 2) begin : g_bad_stages
      $error("pseq_sync: STAGES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q      <= '0;
         last_q <= 1'b0;
      end else begin
         q      <= {q[STAGES-2:0], din};
         last_q <= q[STAGES-1];
      end
   end

   assign rise = q[STAGES-1] & ~last_q;

endmodule

// File: rtl/pseq_timer.sv
// Loadable down counter; last is high while the count is zero.
module pseq_timer #(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         last
);

   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (load)         cnt <= load_val;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign last = (cnt == '0);

endmodule

// File: rtl/pseq_fsm.sv
// Phase sequencer: one state per strobe plus a delay and a handshake wait.
module pseq_fsm
   import pseq_pkg::*;
#(
   parameter int unsigned LEN_W   = 12,
   parameter int unsigned OFS_W   = 12,
   parameter int unsigned TW      = 12,
   parameter int unsigned RST_CYC = 129
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_rise,
   input  logic [LEN_W-1:0]  len_in,
   input  logic [OFS_W-1:0]  ofs_in,
   input  logic              rd_done,
   input  logic              tmr_last,
   output pseq_state_e       state,
   output logic              tmr_load,
   output logic [TW-1:0]     tmr_val
);

   pseq_state_e      nxt;
   logic [LEN_W-1:0] len_q;
   logic [OFS_W-1:0] ofs_q;
   logic [LEN_W-1:0] len_m1;
   logic             accept;

   assign accept = (state == S_IDLE) && trig_rise;
   assign len_m1 = (len_q == '0) ? '0 : len_q - 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE;
         len_q <= '0;
         ofs_q <= '0;
      end else begin
         state <= nxt;
         if (accept) begin
            len_q <= len_in;
            ofs_q <= ofs_in;
         end
      end
   end

   always_comb begin
      nxt      = state;
      tmr_load = 1'b0;
      tmr_val  = '0;
      case (state)
         S_IDLE: if (trig_rise) begin
            nxt      = S_RST;
            tmr_load = 1'b1;
            tmr_val  = TW'(RST_CYC - 1);
         end
         S_RST: if (tmr_last) nxt = S_SHR;
         S_SHR: begin
            tmr_load = 1'b1;
            if (ofs_q != '0) begin
               nxt     = S_DLY;
               tmr_val = TW'(ofs_q - 1'b1);
            end else begin
               nxt     = S_INT;
               tmr_val = TW'(len_m1);
            end
         end
         S_DLY: if (tmr_last) begin
            nxt      = S_INT;
            tmr_load = 1'b1;
            tmr_val  = TW'(len_m1);
         end
         S_INT:  if (tmr_last) nxt = S_SHS;
         S_SHS:  nxt = S_RDS;
         S_RDS:  nxt = S_WAIT;
         S_WAIT: if (rd_done) nxt = S_IDLE;
         default: nxt = S_IDLE;
      endcase
   end

endmodule

// File: rtl/pseq_top.sv
module pseq_top
   import pseq_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 15_000_000,
   parameter int unsigned RST_NS      = 8600,
   parameter int unsigned LEN_W       = 12,
   parameter int unsigned OFS_W       = 12,
   parameter int unsigned CNT_W       = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          OFFSET_EN   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             trig_in,
   input  logic [LEN_W-1:0] int_len,
   input  logic             ofs_en,
   input  logic [OFS_W-1:0] ofs_len,
   input  logic             rd_done,
   output logic             irst,
   output logic             shr,
   output logic             intg,
   output logic             shs,
   output logic             rd_start,
   output logic [CNT_W-1:0] drop_cnt
);

   localparam int unsigned RST_CYC = rst_cycles(CLK_HZ, RST_NS);
   localparam int unsigned RST_W   = $clog2(RST_CYC);
   localparam int unsigned TW      = umax(RST_W, umax(LEN_W, OFS_W));

   if (CLK_HZ > MAX_CLK_HZ) begin : g_bad_clk
      $error("pseq_top: CLK_HZ above the 15 MHz ceiling");
   end
   if (RST_CYC < 2) begin : g_bad_rst
      $error("pseq_top: reset phase shorter than two cycles");
   end
   if (CNT_W < 1 || LEN_W < 1 || OFS_W < 1) begin : g_bad_width
      $error("pseq_top: widths must be nonzero");
   end

   logic             trig_rise;
   logic [OFS_W-1:0] ofs_sel;
   logic             tmr_load;
   logic [TW-1:0]    tmr_val;
   logic             tmr_last;
   pseq_state_e      st;

   if (OFFSET_EN) begin : g_ofs
      assign ofs_sel = ofs_en ? ofs_len : '0;
   end else begin : g_no_ofs
      assign ofs_sel = '0;
   end

   pseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (trig_in),
      .rise  (trig_rise)
   );

   pseq_fsm #(
      .LEN_W   (LEN_W),
      .OFS_W   (OFS_W),
      .TW      (TW),
      .RST_CYC (RST_CYC)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .trig_rise (trig_rise),
      .len_in    (int_len),
      .ofs_in    (ofs_sel),
      .rd_done   (rd_done),
      .tmr_last  (tmr_last),
      .state     (st),
      .tmr_load  (tmr_load),
      .tmr_val   (tmr_val)
   );

   pseq_timer #(.W(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .last     (tmr_last)
   );

   // Discarded-trigger tally, saturating.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         drop_cnt <= '0;
      else if (trig_rise && (st != S_IDLE) && (drop_cnt != '1))
         drop_cnt <= drop_cnt + 1'b1;
   end

   assign irst     = (st == S_RST);
   assign shr      = (st == S_SHR);
   assign intg     = (st == S_INT);
   assign shs      = (st == S_SHS);
   assign rd_start = (st == S_RDS);

endmodule

// File: rtl/pseq_chk.sv
module pseq_chk
   import pseq_pkg::*;
#(
   parameter int unsigned CLK_HZ = 15_000_000,
   parameter int unsigned RST_NS = 8600,
   parameter int unsigned CNT_W  = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             irst,
   input logic             shr,
   input logic             intg,
   input logic             shs,
   input logic             rd_start,
   input logic [CNT_W-1:0] drop_cnt
);

   localparam int unsigned RST_CYC = rst_cycles(CLK_HZ, RST_NS);

   int unsigned run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    run <= 0;
      else if (irst) run <= run + 1;
      else           run <= 0;
   end

   assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({irst, shr, intg, shs, rd_start}));

   assert_rst_not_long_R2: assert property (@(posedge clk) disable iff (!rst_n)
      irst |-> (run < RST_CYC));

   assert_rst_exact_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irst) |-> (run == RST_CYC));

   assert_shr_follows_rst_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irst) |-> shr);

   assert_shs_follows_intg_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(intg) |-> shs);

   assert_rdstart_after_shs_R7: assert property (@(posedge clk) disable iff (!rst_n)
      shs |=> rd_start);

   assert_drop_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_cnt != $past(drop_cnt)) |-> (drop_cnt == $past(drop_cnt) + 1'b1));

endmodule

bind pseq_top pseq_chk #(
   .CLK_HZ (CLK_HZ),
   .RST_NS (RST_NS),
   .CNT_W  (CNT_W)
) u_pseq_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .irst     (irst),
   .shr      (shr),
   .intg     (intg),
   .shs      (shs),
   .rd_start (rd_start),
   .drop_cnt (drop_cnt)
);

// File: tb/test_pseq_top.sv
module test_pseq_top;

   localparam int CLK_PERIOD = 66;
   localparam int RC = int'((longint'(15_000_000) * longint'(8600)) / 64'd1_000_000_000);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        trig_in = 1'b0;
   logic [11:0] int_len = '0;
   logic        ofs_en = 1'b0;
   logic [11:0] ofs_len = '0;
   logic        rd_done = 1'b0;
   logic        irst, shr, intg, shs, rd_start;
   logic [7:0]  drop_cnt;

   int n_cmp = 0;
   int n_bad = 0;
   int exp_drop = 0;
   bit finished = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pseq_top i_pseq_top (
      .clk      (clk),
      .rst_n    (rst_n),
      .trig_in  (trig_in),
      .int_len  (int_len),
      .ofs_en   (ofs_en),
      .ofs_len  (ofs_len),
      .rd_done  (rd_done),
      .irst     (irst),
      .shr      (shr),
      .intg     (intg),
      .shs      (shs),
      .rd_start (rd_start),
      .drop_cnt (drop_cnt)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic bump_drop();
      if (exp_drop < 255) exp_drop++;
   endtask

   task automatic toggle_trig();
      trig_in = 1'b1;
      repeat (2) @(negedge clk);
      trig_in = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   // One acquisition. Expected strobe positions are counted in negedges after trig_in rises.
   task automatic run_pulse(input int len, input int ofs, input bit oen, input bit hold,
                            input bit extra, input int wait_drops);
      int le, oe, last_k;
      le = (len == 0) ? 1 : len;
      oe = oen ? ofs : 0;
      last_k = 5 + RC + oe + le;
      @(negedge clk);
      int_len = 12'(len);
      ofs_len = 12'(ofs);
      ofs_en  = oen;
      trig_in = 1'b1;
      for (int k = 1; k <= last_k + 3; k++) begin
         @(negedge clk);
         chk("R2 irst", int'(irst), int'(k >= 3 && k <= 2 + RC));
         chk("R3 shr", int'(shr), int'(k == 3 + RC));
         chk("R4/R5 intg", int'(intg), int'(k >= 4 + RC + oe && k <= 3 + RC + oe + le));
         chk("R6 shs", int'(shs), int'(k == 4 + RC + oe + le));
         chk("R7 rd_start", int'(rd_start), int'(k == 5 + RC + oe + le));
         if (k == 10 && !hold) trig_in = 1'b0;
         if (k == 20) begin // R9: settings changed mid-cycle
            int_len = 12'(len ^ 'h5A5);
            ofs_len = 12'(ofs + 3);
            ofs_en  = !oen;
         end
         if (extra && k == 40) trig_in = 1'b1;
         if (extra && k == 50) trig_in = 1'b0;
      end
      if (extra) bump_drop();
      for (int i = 0; i < wait_drops; i++) begin
         toggle_trig();
         bump_drop();
      end
      // R7: nothing moves while waiting for the handshake
      chk("R7 wait idle", int'({irst, shr, intg, shs, rd_start}), 0);
      rd_done = 1'b1;
      @(negedge clk);
      rd_done = 1'b0;
      @(negedge clk);
      chk("R8 drop_cnt", int'(drop_cnt), exp_drop);
      if (hold) begin
         for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R10 held trigger no restart", int'({irst, shr, intg, shs, rd_start}), 0);
         end
         trig_in = 1'b0;
         repeat (3) @(negedge clk);
      end
   endtask

   initial begin
      int lens[7];
      int offs[3];
      lens = '{0, 1, 2, 3, 5, 17, 4095};
      offs = '{0, 1, 4};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1
      chk("R1 strobes after reset", int'({irst, shr, intg, shs, rd_start}), 0);
      chk("R1 drop_cnt after reset", int'(drop_cnt), 0);

      foreach (lens[i]) begin
         foreach (offs[j]) begin
            for (int e = 0; e < 2; e++) begin
               run_pulse(lens[i], offs[j], bit'(e), 1'b0, bit'((i + j) % 2), (i == 2) ? 2 : 0);
            end
         end
      end

      run_pulse(4, 2, 1'b1, 1'b1, 1'b0, 0);   // R10
      run_pulse(6, 0, 1'b0, 1'b0, 1'b0, 0);   // R10 fresh edge starts normally

      // R8 saturation: many discarded edges while awaiting rd_done
      run_pulse(3, 0, 1'b0, 1'b0, 1'b0, 260);
      chk("R8 saturated", int'(drop_cnt), 255);

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 200000);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule